// File: doc/BRIEF.md
# Scaled Flow Control Credit Gate

This block sits on the transmit side of a packet link and decides whether an outgoing packet may be sent. It tracks what the receiving partner has advertised for three traffic classes: posted, non-posted and completion. Each class has a header credit pool and a data credit pool, which gives six pools in all. For every pool the partner chooses a multiplier of 1x, 4x or 16x. The advertised count is multiplied by that factor before it becomes a credit limit. One data credit stands for 16 bytes of payload.

A sequencer walks through initialization in a fixed order. It starts in `ST_AWAIT_POST`. An initial advertisement for the posted class moves it to `ST_AWAIT_NONPOST` (transition T_POST_DONE). An initial advertisement for the non-posted class moves it to `ST_AWAIT_CMPL` (T_NONPOST_DONE). An initial advertisement for the completion class moves it to `ST_RUN` (T_CMPL_DONE). It then stays in `ST_RUN` until reset. Any advertisement that does not match the awaited class leaves the state unchanged. In `ST_RUN`, update advertisements replace a pool's limit.

A pending packet presents its class and its data credit count. The grant is combinational in the same cycle. Each pool keeps a limit counter and a consumed counter, both modular. A grant advances the consumed counters at the next clock edge.

Top module: `fcg_credit_gate`

## Requirements
- R1: While `rst_n` is low, `gnt` and `link_ready` are 0 whatever the request inputs are.
- R2: Initial advertisements (`adv_is_init`=1) are accepted only in the order posted (class code 0), then non-posted (1), then completion (2). An advertisement for any other class leaves the sequencer in its state. `link_ready` rises on the clock edge that accepts the completion advertisement.
- R3: Each pool decodes its own 2-bit scale code: 00 and 01 mean 1x, 10 means 4x, 11 means 16x. An accepted initial advertisement sets the header limit to header count × header factor and the data limit to data count × data factor.
- R4: `gnt` is 1 exactly when `req_valid` and `link_ready` are 1, the header test passes and the data test passes for `req_cls`. The header test is (limit − (consumed + 1)) mod 4096 ≤ 2048. The data test is (limit − (consumed + `req_dat_cred`)) mod 65536 ≤ 32768.
- R5: On a grant, the class's header consumed counter increases by 1 and its data consumed counter increases by `req_dat_cred`, both at the same edge. Other classes do not change.
- R6: In `ST_RUN`, an update (`adv_is_init`=0, class 0 to 2) replaces that class's limits with count × the factor latched at initialization, and the update's scale fields are ignored. Updates arriving before `ST_RUN` and initial advertisements arriving in `ST_RUN` are ignored.
- R7: When an update and a request arrive in the same cycle, the grant decision uses the limit held before the update. The new limit takes effect from the next cycle.
- R8: A request with class code 3 is never granted.
- R9: The largest advertisements are tracked exactly: 127 headers × 16 = 2032 and 2047 data × 16 = 32752. A packet that uses exactly the remaining credits is granted, and one more credit is refused.
- R10: The counters wrap at 12 bits (header) and 16 bits (data). Grants stay correct after the consumed counters have passed a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_valid | input | 1 | Advertisement present this cycle |
| adv_is_init | input | 1 | 1 = initial advertisement, 0 = update |
| adv_cls | input | 2 | Advertised class: 0 posted, 1 non-posted, 2 completion |
| adv_hdr_scale | input | 2 | Header scale code |
| adv_dat_scale | input | 2 | Data scale code |
| adv_hdr_cnt | input | 8 | Advertised header count (unscaled) |
| adv_dat_cnt | input | 12 | Advertised data count (unscaled) |
| req_valid | input | 1 | Pending packet present |
| req_cls | input | 2 | Class of the pending packet |
| req_dat_cred | input | 10 | Data credits the packet needs |
| gnt | output | 1 | Packet accepted this cycle |
| link_ready | output | 1 | Initialization complete |

## Verification
A wrong limit, consumed count or latched scale inside a pool is not visible until that pool nears exhaustion. At that point `gnt` is given or withheld one packet early or late. For this reason the sweeps drain every pool to its boundary and probe the last credit and one beyond it. A sequencer fault shows on `link_ready` and on `gnt` in the cycle after the faulty advertisement. Wrap faults stay hidden until the consumed counter crosses 4096 headers or 65536 data credits, so the bench runs well past both.

// File: rtl/fcg_pkg.sv
`timescale 1ns/1ps
package fcg_pkg;
    localparam int NUM_CLS = 3;

    typedef enum logic [1:0] {
        CLS_POST    = 2'd0,
        CLS_NONPOST = 2'd1,
        CLS_CMPL    = 2'd2,
        CLS_NONE    = 2'd3
    } fc_cls_e;

    typedef enum logic [1:0] {
        ST_AWAIT_POST,
        ST_AWAIT_NONPOST,
        ST_AWAIT_CMPL,
        ST_RUN
    } gate_state_e;

    localparam logic [1:0] SCALE_X4  = 2'b10;
    localparam logic [1:0] SCALE_X16 = 2'b11;
    localparam int SHIFT_X4  = 2;
    localparam int SHIFT_X16 = 4;
endpackage

// File: rtl/fcg_scale.sv
`timescale 1ns/1ps
module fcg_scale #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 12
) (
    input  logic [1:0]       code,
    input  logic [IN_W-1:0]  cnt,
    output logic [OUT_W-1:0] scaled
);
    import fcg_pkg::*;

    localparam int PAD_W = OUT_W - IN_W;

    logic [OUT_W-1:0] wide;

    assign wide = {{PAD_W{1'b0}}, cnt};

    always_comb begin
        unique case (code)
            SCALE_X4:  scaled = wide << SHIFT_X4;
            SCALE_X16: scaled = wide << SHIFT_X16;
            default:   scaled = wide;
        endcase
    end

    initial begin
        assert (PAD_W >= SHIFT_X16) else $error("scale output too narrow");
    end
endmodule

// File: rtl/fcg_credit_cell.sv
`timescale 1ns/1ps
module fcg_credit_cell #(
    parameter int CNT_W  = 8,
    parameter int CR_W   = 12,
    parameter int NEED_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_load,
    input  logic              upd_load,
    input  logic [1:0]        code_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [NEED_W-1:0] need,
    input  logic              consume,
    output logic              ok
);
    localparam logic [CR_W-1:0] HALF = {1'b1, {(CR_W-1){1'b0}}};

    logic [1:0]      scale_q;
    logic [1:0]      code_sel;
    logic [CR_W-1:0] limit_q;
    logic [CR_W-1:0] used_q;
    logic [CR_W-1:0] scaled;
    logic [CR_W-1:0] need_ext;
    logic [CR_W-1:0] margin;
    logic            load;

    assign load     = init_load | upd_load;
    assign code_sel = init_load ? code_in : scale_q;
    assign need_ext = {{(CR_W-NEED_W){1'b0}}, need};

    fcg_scale #(.IN_W(CNT_W), .OUT_W(CR_W)) u_scale (
        .code   (code_sel),
        .cnt    (cnt_in),
        .scaled (scaled)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_q <= 2'b00;
            limit_q <= '0;
        end else begin
            if (init_load) scale_q <= code_in;
            if (load)      limit_q <= scaled;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) used_q <= '0;
        else if (consume) used_q <= used_q + need_ext;
    end

    assign margin = limit_q - (used_q + need_ext);
    assign ok     = (margin <= HALF);

    p_used_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> used_q == $past(used_q + need_ext));
    p_used_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !consume |=> $stable(used_q));
    p_limit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(limit_q));
    p_consume_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> ok);
    p_scale_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_load |=> $stable(scale_q));
endmodule

// File: rtl/fcg_init_seq.sv
`timescale 1ns/1ps
module fcg_init_seq #(
    parameter int NCLS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_valid,
    input  logic            adv_is_init,
    input  logic [1:0]      adv_cls,
    output logic [NCLS-1:0] init_load,
    output logic [NCLS-1:0] upd_load,
    output logic            ready
);
    import fcg_pkg::*;

    gate_state_e state_q, state_d;
    logic [1:0]  expect_cls;
    logic        init_hit;
    logic        upd_hit;

    assign init_hit = adv_valid && adv_is_init && (adv_cls == expect_cls) && (state_q != ST_RUN);
    assign upd_hit  = adv_valid && !adv_is_init && (state_q == ST_RUN) && (adv_cls != CLS_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAIT_POST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAIT_POST:    if (init_hit) state_d = ST_AWAIT_NONPOST;
            ST_AWAIT_NONPOST: if (init_hit) state_d = ST_AWAIT_CMPL;
            ST_AWAIT_CMPL:    if (init_hit) state_d = ST_RUN;
            ST_RUN:           state_d = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_AWAIT_POST:    expect_cls = CLS_POST;
            ST_AWAIT_NONPOST: expect_cls = CLS_NONPOST;
            ST_AWAIT_CMPL:    expect_cls = CLS_CMPL;
            ST_RUN:           expect_cls = CLS_NONE;
        endcase
        ready = (state_q == ST_RUN);
        for (int c = 0; c < NCLS; c++) begin
            init_load[c] = init_hit && (adv_cls == 2'(c));
            upd_load[c]  = upd_hit && (adv_cls == 2'(c));
        end
    end

    p_ready_after_cmpl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AWAIT_CMPL && adv_valid && adv_is_init && adv_cls == CLS_CMPL) |=> ready);
    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    p_one_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_load, upd_load}));
    p_no_upd_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_load) |-> ready);
endmodule

// File: rtl/fcg_credit_gate.sv
`timescale 1ns/1ps
module fcg_credit_gate #(
    parameter int HCNT_W = 8,
    parameter int DCNT_W = 12,
    parameter int HCR_W  = 12,
    parameter int DCR_W  = 16,
    parameter int PKT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_valid,
    input  logic              adv_is_init,
    input  logic [1:0]        adv_cls,
    input  logic [1:0]        adv_hdr_scale,
    input  logic [1:0]        adv_dat_scale,
    input  logic [HCNT_W-1:0] adv_hdr_cnt,
    input  logic [DCNT_W-1:0] adv_dat_cnt,
    input  logic              req_valid,
    input  logic [1:0]        req_cls,
    input  logic [PKT_W-1:0]  req_dat_cred,
    output logic              gnt,
    output logic              link_ready
);
    import fcg_pkg::*;

    localparam int NCLS  = NUM_CLS;
    localparam int SEL_N = 4;

    logic [NCLS-1:0]  init_load;
    logic [NCLS-1:0]  upd_load;
    logic [NCLS-1:0]  hdr_ok;
    logic [NCLS-1:0]  dat_ok;
    logic [NCLS-1:0]  consume;
    logic [SEL_N-1:0] hdr_ok_v;
    logic [SEL_N-1:0] dat_ok_v;

    fcg_init_seq #(.NCLS(NCLS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_valid   (adv_valid),
        .adv_is_init (adv_is_init),
        .adv_cls     (adv_cls),
        .init_load   (init_load),
        .upd_load    (upd_load),
        .ready       (link_ready)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        fcg_credit_cell #(.CNT_W(HCNT_W), .CR_W(HCR_W), .NEED_W(1)) u_hdr (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_load (init_load[c]),
            .upd_load  (upd_load[c]),
            .code_in   (adv_hdr_scale),
            .cnt_in    (adv_hdr_cnt),
            .need      (1'b1),
            .consume   (consume[c]),
            .ok        (hdr_ok[c])
        );
        fcg_credit_cell #(.CNT_W(DCNT_W), .CR_W(DCR_W), .NEED_W(PKT_W)) u_dat (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_load (init_load[c]),
            .upd_load  (upd_load[c]),
            .code_in   (adv_dat_scale),
            .cnt_in    (adv_dat_cnt),
            .need      (req_dat_cred),
            .consume   (consume[c]),
            .ok        (dat_ok[c])
        );
        assign consume[c] = gnt && (req_cls == 2'(c));
    end

    assign hdr_ok_v = {{(SEL_N-NCLS){1'b0}}, hdr_ok};
    assign dat_ok_v = {{(SEL_N-NCLS){1'b0}}, dat_ok};

    assign gnt = req_valid && link_ready && (req_cls != CLS_NONE)
                 && hdr_ok_v[req_cls] && dat_ok_v[req_cls];

    p_gnt_needs_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> link_ready);
    p_gnt_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> (req_cls != CLS_NONE));
    p_gnt_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> req_valid);
    p_single_consume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(consume));
endmodule

// File: tb/fcg_credit_gate_tb.sv
`timescale 1ns/1ps
module fcg_credit_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adv_valid = 0, adv_is_init = 0;
    logic [1:0] adv_cls = 0, adv_hdr_scale = 0, adv_dat_scale = 0;
    logic [7:0] adv_hdr_cnt = 0;
    logic [11:0] adv_dat_cnt = 0;
    logic       req_valid = 0;
    logic [1:0] req_cls = 0;
    logic [9:0] req_dat_cred = 0;
    logic       gnt, link_ready;

    int total = 0;
    int bad = 0;

    logic [11:0] m_lh [3];
    logic [11:0] m_ch [3];
    logic [15:0] m_ld [3];
    logic [15:0] m_cd [3];
    logic [1:0]  m_sh [3];
    logic [1:0]  m_sd [3];
    bit          m_ready;
    int          m_exp;

    always #2 clk = ~clk;

    fcg_credit_gate u_dut (
        .clk(clk), .rst_n(rst_n), .adv_valid(adv_valid), .adv_is_init(adv_is_init),
        .adv_cls(adv_cls), .adv_hdr_scale(adv_hdr_scale), .adv_dat_scale(adv_dat_scale),
        .adv_hdr_cnt(adv_hdr_cnt), .adv_dat_cnt(adv_dat_cnt), .req_valid(req_valid),
        .req_cls(req_cls), .req_dat_cred(req_dat_cred), .gnt(gnt), .link_ready(link_ready)
    );

    function automatic int fac(input logic [1:0] c);
        if (c == 2'b10) return 4;
        if (c == 2'b11) return 16;
        return 1;
    endfunction

    function automatic bit model_gnt(input bit rv, input logic [1:0] rc, input logic [9:0] rd);
        logic [11:0] hm;
        logic [15:0] dm;
        if (!rv || !m_ready || rc == 2'd3) return 0;
        hm = m_lh[rc] - (m_ch[rc] + 12'd1);
        dm = m_ld[rc] - (m_cd[rc] + {6'd0, rd});
        return (hm <= 12'd2048) && (dm <= 16'd32768);
    endfunction

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit av, input bit ai, input logic [1:0] ac, input logic [1:0] hs,
                        input logic [1:0] ds, input int hc, input int dc,
                        input bit rv, input logic [1:0] rc, input int rd, input string tag);
        bit eg;
        @(negedge clk);
        adv_valid = av; adv_is_init = ai; adv_cls = ac; adv_hdr_scale = hs;
        adv_dat_scale = ds; adv_hdr_cnt = 8'(hc); adv_dat_cnt = 12'(dc);
        req_valid = rv; req_cls = rc; req_dat_cred = 10'(rd);
        #1;
        eg = model_gnt(rv, rc, 10'(rd));
        chk(gnt == eg, {tag, " gnt"}, int'(gnt), int'(eg));
        chk(link_ready == m_ready, {tag, " link_ready"}, int'(link_ready), int'(m_ready));
        @(posedge clk);
        if (eg) begin
            m_ch[rc] = m_ch[rc] + 12'd1;
            m_cd[rc] = m_cd[rc] + 16'(rd);
        end
        if (av) begin
            if (ai && !m_ready && int'(ac) == m_exp) begin
                m_sh[ac] = hs; m_sd[ac] = ds;
                m_lh[ac] = 12'(hc * fac(hs));
                m_ld[ac] = 16'(dc * fac(ds));
                m_exp++;
                if (m_exp == 3) m_ready = 1;
            end else if (!ai && m_ready && ac != 2'd3) begin
                m_lh[ac] = 12'(hc * fac(m_sh[ac]));
                m_ld[ac] = 16'(dc * fac(m_sd[ac]));
            end
        end
    endtask

    task automatic req(input logic [1:0] rc, input int rd, input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 1, rc, rd, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        adv_valid = 1; adv_is_init = 1; adv_cls = 0; req_valid = 1; req_cls = 0; req_dat_cred = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(gnt == 0, "R1 gnt in reset", int'(gnt), 0);
            chk(link_ready == 0, "R1 ready in reset", int'(link_ready), 0);
        end
        for (int c = 0; c < 3; c++) begin
            m_lh[c] = 0; m_ch[c] = 0; m_ld[c] = 0; m_cd[c] = 0; m_sh[c] = 0; m_sd[c] = 0;
        end
        m_ready = 0; m_exp = 0;
        adv_valid = 0; req_valid = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic init_cls(input logic [1:0] c, input logic [1:0] hs, input logic [1:0] ds,
                            input int hc, input int dc);
        step(1, 1, c, hs, ds, hc, dc, 0, 0, 0, "R2 init");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R2 / R6: ordering, misordered init and early updates are ignored
        do_reset();
        req(0, 0, "R2 no grant before init");
        step(1, 1, 1, 3, 3, 9, 9, 1, 0, 0, "R2 out-of-order nonposted");
        step(1, 1, 2, 3, 3, 9, 9, 0, 0, 0, "R2 out-of-order completion");
        step(1, 0, 0, 3, 3, 9, 9, 0, 0, 0, "R6 update before run");
        init_cls(0, 1, 1, 4, 8);
        step(1, 0, 1, 1, 1, 9, 9, 0, 0, 0, "R6 update before run");
        init_cls(1, 1, 1, 4, 8);
        step(1, 1, 0, 1, 1, 9, 9, 0, 0, 0, "R2 repeat posted ignored");
        init_cls(2, 1, 1, 4, 8);
        req(0, 1, "R2 ready then grant");
        for (int i = 0; i < 6; i++) req(0, 1, "R4 posted drain");
        req(3, 0, "R8 class three");
        req(1, 8, "R4 exact data");
        req(1, 1, "R4 data exhausted");

        // R3 sweep of header and data scale codes on every class
        for (int hs = 0; hs < 4; hs++) begin
            for (int ds = 0; ds < 4; ds++) begin
                do_reset();
                init_cls(0, 2'(hs), 2'(ds), 3, 5);
                init_cls(1, 2'((hs + 1) % 4), 2'((ds + 2) % 4), 2, 7);
                init_cls(2, 2'(3 - hs), 2'(3 - ds), 1, 2);
                for (int i = 0; i < 50; i++) req(0, 0, "R3 posted header scale");
                for (int i = 0; i < 18; i++) req(1, 7, "R3 nonposted data scale");
                for (int i = 0; i < 4; i++) req(2, 2 * fac(2'(3 - ds)) - 1, "R3 completion mixed");
                req(3, 0, "R8 class three sweep");
            end
        end

        // R9: largest advertised values
        do_reset();
        init_cls(0, 3, 3, 127, 2047);
        init_cls(1, 0, 0, 1, 1);
        init_cls(2, 0, 0, 1, 1);
        for (int i = 0; i < 128; i++) req(0, 256, "R9 data max drain");
        req(0, 241, "R9 one credit beyond");
        req(0, 240, "R9 exact remainder");
        for (int i = 0; i < 1910; i++) req(0, 0, "R9 header max drain");

        // R6 / R7: updates, latched scale, same-cycle order
        do_reset();
        init_cls(0, 2, 1, 2, 100);
        init_cls(1, 0, 0, 1, 1);
        init_cls(2, 0, 0, 1, 1);
        for (int i = 0; i < 9; i++) req(0, 1, "R6 initial limit");
        step(1, 0, 0, 3, 3, 4, 100, 1, 0, 1, "R7 update with request refused");
        req(0, 1, "R7 new limit next cycle");
        for (int i = 0; i < 8; i++) req(0, 1, "R6 latched scale");
        step(1, 1, 0, 3, 3, 100, 100, 0, 0, 0, "R6 init in run");
        req(0, 1, "R6 init in run ignored");
        step(1, 0, 0, 0, 0, 3, 100, 1, 1, 0, "R5 other class grant");
        step(1, 0, 0, 0, 0, 5, 100, 0, 0, 0, "R6 raise limit");
        for (int i = 0; i < 2; i++) req(0, 1, "R5 consume");
        step(1, 0, 0, 0, 0, 3, 100, 1, 0, 1, "R7 grant on old limit");
        req(0, 1, "R7 lowered limit");

        // R10: wrap of both counters at 16x
        do_reset();
        init_cls(0, 3, 3, 64, 1024);
        init_cls(1, 0, 0, 1, 1);
        init_cls(2, 0, 0, 1, 1);
        for (int k = 1; k <= 6; k++) begin
            for (int i = 0; i < 1026; i++) req(0, 16, "R10 wrap drain");
            step(1, 0, 0, 0, 0, ((k + 1) * 64) % 256, ((k + 1) * 1024) % 4096, 0, 0, 0, "R10 update");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule